// File: doc/BRIEF.md
# Burst-of-Four Double-Rate Static Memory Core

This block is a synchronous, pipelined static memory that moves data in bursts of four words. Everything runs in a single beat clock. The beats alternate in phase. An even beat stands for the rising edge of the main clock, and an odd beat stands for the rising edge of its complement. This gives two data words per main-clock period. A single accepted address moves four words, one per beat, on consecutive beats.

Every input (load strobe, read/write select, address, write data and byte write enables) passes through an input register before the control logic sees it. A command is taken only from a load strobe that arrives on an even beat while no burst is running, so at most one command is taken every four beats. The burst order starts at the word named by the two low address bits and wraps inside the aligned block of four. A build option forces the start to word zero for narrow configurations.

The control is a three-state machine:
- **S_IDLE** waits for a command. It takes transition *accept-write* to **S_WRITE** or *accept-read* to **S_READ**, and it performs the first beat of that burst in the accepting cycle.
- **S_WRITE** and **S_READ** each perform beats one to three of their burst. After the fourth beat they take transition *burst-done* back to S_IDLE; otherwise they stay in their state.

A load strobe that cannot be taken is dropped and reported on a one-beat error flag.

Top module: `ddrb4_sram`

## Requirements
- R1: After reset, `rvalid`, `perr` and `rdata` are zero, `kphase` is 0 (even) on the first beat, and every memory word reads back as zero.
- R2: `kphase` toggles on every beat: 0 marks an even (main-edge) beat and 1 marks an odd (complement-edge) beat.
- R3: A command is accepted only when `ld` is high on a beat with `kphase`=0 and no burst is in progress. `rw`=1 selects read and `rw`=0 selects write. Each accepted command moves exactly four words on four consecutive beats, and no other command is accepted during those beats.
- R4: In the default build, the word order starts at `addr[1:0]` and increments modulo 4 inside the block `addr[AW-1:2]`. For example, start 2 gives words 2,3,0,1.
- R5: With `START_ZERO`=1, the burst always starts at word 0 of the block, whatever `addr[1:0]` is.
- R6: Write word k of a burst is presented on `wdata`, together with its enables on `wbe`, on beat t+k, where t is the command beat. Byte lane i is bits [9i+8:9i] of the word. A lane is stored only if `wbe[i]`=1, and lanes with `wbe[i]`=0 keep their old contents.
- R7: For a read accepted at beat t, word k appears on `rdata` at beat t+3+k. `rvalid` is high for exactly those four beats, and `rdata` is zero on beats where `rvalid` is low.
- R8: A `ld` on an odd beat, or one that arrives while a burst is in progress, is ignored: it writes nothing and returns no data. `perr` is high for one beat at t+2 for each such strobe.
- R9: A read issued on the first legal beat after a write burst (four beats after the write command) to the same block returns the newly written words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld | input | 1 | Load strobe, starts a command |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address; the low two bits give the burst start |
| wdata | input | DW | Write word for the current beat |
| wbe | input | NB | Per-lane write enables for the current beat, active high |
| kphase | output | 1 | Beat phase, 0 = even, 1 = odd |
| rdata | output | DW | Read word |
| rvalid | output | 1 | High on the four beats of read data |
| perr | output | 1 | One-beat flag for a rejected load strobe |

## Verification
The bench issues a write whose start word is 2 and then reads the whole block from word 0. A design that counted linearly past the block edge, instead of wrapping, would put words into the next block, and the read-back would show zeros in their place. Masked writes change the enables on every beat. This exposes a design that latches the enables once per command, or that stores a lane whose enable is clear. Load strobes are placed on an odd beat and in the middle of bursts, and they carry write data. A design that honoured them would either corrupt a later read-back or shift `rvalid`. A read issued right after a write to the same block catches a read that races ahead of the last write beat.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WRITE = 2'd1,
        S_READ  = 2'd2
    } burst_state_e;
endpackage

// File: rtl/ddrb_inreg.sv
module ddrb_inreg #(
    parameter int AW = 6,
    parameter int DW = 18,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] wbe,
    output logic          kphase,
    output logic          c_ld,
    output logic          c_rw,
    output logic [AW-1:0] c_addr,
    output logic [DW-1:0] c_wdata,
    output logic [NB-1:0] c_wbe,
    output logic          c_odd
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            c_ld    <= 1'b0;
            c_rw    <= 1'b0;
            c_addr  <= '0;
            c_wdata <= '0;
            c_wbe   <= '0;
            c_odd   <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
            c_ld    <= ld;
            c_rw    <= rw;
            c_addr  <= addr;
            c_wdata <= wdata;
            c_wbe   <= wbe;
            c_odd   <= phase_q;
        end
    end

    assign kphase = phase_q;
endmodule

// File: rtl/ddrb_ctrl.sv
module ddrb_ctrl
    import ddrb_pkg::*;
#(
    parameter int AW         = 6,
    parameter bit START_ZERO = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          c_ld,
    input  logic          c_rw,
    input  logic [AW-1:0] c_addr,
    input  logic          c_odd,
    output logic          acc,
    output logic          op_we,
    output logic          op_rd,
    output logic [AW-1:0] op_addr,
    output logic          busy,
    output logic          perr
);
    localparam int BW = AW - 2;

    burst_state_e state_q, state_d;
    logic [1:0]    beat_q, beat_d;
    logic [1:0]    start_q, start_d;
    logic [BW-1:0] blk_q, blk_d;
    logic          perr_q;
    logic [1:0]    start_sel;
    logic [1:0]    lo_idx;

    generate
        if (START_ZERO) begin : g_start_zero
            assign start_sel = 2'd0;
        end else begin : g_start_addr
            assign start_sel = c_addr[1:0];
        end
    endgenerate

    assign lo_idx = start_q + beat_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beat_q  <= 2'd0;
            start_q <= 2'd0;
            blk_q   <= '0;
            perr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            start_q <= start_d;
            blk_q   <= blk_d;
            perr_q  <= c_ld && !acc;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        start_d = start_q;
        blk_d   = blk_q;
        acc     = 1'b0;
        op_we   = 1'b0;
        op_rd   = 1'b0;
        op_addr = {blk_q, lo_idx};
        unique case (state_q)
            S_IDLE: begin
                if (c_ld && !c_odd) begin
                    acc     = 1'b1;
                    op_we   = !c_rw;
                    op_rd   = c_rw;
                    op_addr = {c_addr[AW-1:2], start_sel};
                    state_d = c_rw ? S_READ : S_WRITE;
                    beat_d  = 2'd1;
                    start_d = start_sel;
                    blk_d   = c_addr[AW-1:2];
                end
            end
            S_WRITE: begin
                op_we  = 1'b1;
                beat_d = beat_q + 2'd1;
                if (beat_q == 2'd3) state_d = S_IDLE;
            end
            S_READ: begin
                op_rd  = 1'b1;
                beat_d = beat_q + 2'd1;
                if (beat_q == 2'd3) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign busy = (state_q != S_IDLE);
    assign perr = perr_q;
endmodule

// File: rtl/ddrb_array.sv
module ddrb_array #(
    parameter int AW = 6,
    parameter int DW = 18,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] wbe,
    output logic [DW-1:0] rword
);
    localparam int WORDS = 1 << AW;
    localparam int LW    = DW / NB;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] merged;

    assign rword = mem[addr];

    generate
        for (genvar ln = 0; ln < NB; ln++) begin : g_lane
            assign merged[ln*LW +: LW] = wbe[ln] ? wdata[ln*LW +: LW]
                                                 : rword[ln*LW +: LW];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= merged;
        end
    end
endmodule

// File: rtl/ddrb_rdpipe.sv
module ddrb_rdpipe #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic [DW-1:0] rword,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);
    logic          s1_v;
    logic [DW-1:0] s1_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_d   <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            s1_v   <= rd;
            s1_d   <= rword;
            rvalid <= s1_v;
            rdata  <= s1_v ? s1_d : '0;
        end
    end
endmodule

// File: rtl/ddrb4_sram.sv
module ddrb4_sram #(
    parameter int AW         = 6,
    parameter int DW         = 18,
    parameter int NB         = 2,
    parameter bit START_ZERO = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          rw,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB-1:0] wbe,
    output logic          kphase,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          perr
);
    logic          c_ld, c_rw, c_odd;
    logic [AW-1:0] c_addr;
    logic [DW-1:0] c_wdata;
    logic [NB-1:0] c_wbe;
    logic          acc, op_we, op_rd, busy;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] rword;

    ddrb_inreg #(.AW(AW), .DW(DW), .NB(NB)) u_in (
        .clk(clk), .rst_n(rst_n), .ld(ld), .rw(rw), .addr(addr),
        .wdata(wdata), .wbe(wbe), .kphase(kphase), .c_ld(c_ld),
        .c_rw(c_rw), .c_addr(c_addr), .c_wdata(c_wdata), .c_wbe(c_wbe),
        .c_odd(c_odd)
    );

    ddrb_ctrl #(.AW(AW), .START_ZERO(START_ZERO)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .c_ld(c_ld), .c_rw(c_rw),
        .c_addr(c_addr), .c_odd(c_odd), .acc(acc), .op_we(op_we),
        .op_rd(op_rd), .op_addr(op_addr), .busy(busy), .perr(perr)
    );

    ddrb_array #(.AW(AW), .DW(DW), .NB(NB)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(op_we), .addr(op_addr),
        .wdata(c_wdata), .wbe(c_wbe), .rword(rword)
    );

    ddrb_rdpipe #(.DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd(op_rd), .rword(rword),
        .rvalid(rvalid), .rdata(rdata)
    );
endmodule

// File: rtl/ddrb4_sram_chk.sv
module ddrb4_sram_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ld,
    input logic          kphase,
    input logic          acc,
    input logic          op_rd,
    input logic          busy,
    input logic [AW-1:0] op_addr,
    input logic          perr,
    input logic          rvalid
);
    logic started;

    always_ff @(posedge clk) begin
        if (!rst_n) started <= 1'b0;
        else        started <= 1'b1;
    end

    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (kphase != $past(kphase)));  // R2

    AST_ACCEPT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ($past(kphase) == 1'b0));  // R3

    AST_NO_REACCEPT_1: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !acc);  // R3

    AST_NO_REACCEPT_2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##2 !acc);  // R3

    AST_NO_REACCEPT_3: assert property (@(posedge clk) disable iff (!rst_n)
        acc |-> ##3 !acc);  // R3

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (op_addr[1:0] == $past(op_addr[1:0]) + 2'd1) &&
                 (op_addr[AW-1:2] == $past(op_addr[AW-1:2])));  // R4

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_rd) |-> ##2 rvalid);  // R7

    AST_ODD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && kphase) |=> (!acc ##1 perr));  // R8
endmodule

bind ddrb4_sram ddrb4_sram_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld(ld), .kphase(kphase), .acc(acc),
    .op_rd(op_rd), .busy(busy), .op_addr(op_addr), .perr(perr),
    .rvalid(rvalid)
);

// File: tb/sim_ddrb4_sram.sv
module sim_ddrb4_sram;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld = 1'b0, rw = 1'b0;
    logic [5:0]  addr = '0;
    logic [17:0] wdata = '0;
    logic [1:0]  wbe = '0;
    logic        kphase, rvalid, perr;
    logic [17:0] rdata;
    logic        kphase1, rvalid1, perr1;
    logic [17:0] rdata1;

    logic [17:0] m0 [64];
    logic [17:0] m1 [64];
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddrb4_sram u0 (
        .clk(clk), .rst_n(rst_n), .ld(ld), .rw(rw), .addr(addr),
        .wdata(wdata), .wbe(wbe), .kphase(kphase), .rdata(rdata),
        .rvalid(rvalid), .perr(perr)
    );

    ddrb4_sram #(.START_ZERO(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .ld(ld), .rw(rw), .addr(addr),
        .wdata(wdata), .wbe(wbe), .kphase(kphase1), .rdata(rdata1),
        .rvalid(rvalid1), .perr(perr1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic align();
        @(negedge clk);
        while (kphase) @(negedge clk);
    endtask

    task automatic model_write(input logic [5:0] a, input int k,
                               input logic [17:0] d, input logic [1:0] be);
        logic [5:0] i0, i1;
        i0 = {a[5:2], 2'(a[1:0] + 2'(k))};
        i1 = {a[5:2], 2'(k)};
        if (be[0]) begin m0[i0][8:0] = d[8:0];   m1[i1][8:0] = d[8:0];   end
        if (be[1]) begin m0[i0][17:9] = d[17:9]; m1[i1][17:9] = d[17:9]; end
    endtask

    task automatic check_read_beat(input logic [5:0] a, input int k);
        logic [5:0] i0, i1;
        i0 = {a[5:2], 2'(a[1:0] + 2'(k))};
        i1 = {a[5:2], 2'(k)};
        chk("R7 rvalid", rvalid, 1);
        chk("R4 order", rdata, m0[i0]);
        chk("R5 zero start", rdata1, m1[i1]);
    endtask

    // One command at an even beat; optional intruding strobe at beat ib.
    task automatic burst(input logic is_rd, input logic [5:0] a,
                         input logic [71:0] wd, input logic [7:0] be,
                         input int ib, input logic ib_rw);
        align();
        for (int b = 0; b < 9; b++) begin
            if (is_rd && b >= 3 && b <= 6) check_read_beat(a, b - 3);
            else begin
                chk("R7 rvalid low", rvalid, 0);
                chk("R7 rdata zero", rdata, 0);
            end
            chk("R8 perr", perr, (ib >= 0 && b == ib + 2) ? 1 : 0);
            ld    = (b == 0) || (b == ib);
            rw    = (b == 0) ? is_rd : ib_rw;
            addr  = (b == 0) ? a : 6'h20;
            wdata = (b < 4) ? wd[b*18 +: 18] : 18'h2A5A5;
            wbe   = (b < 4) ? be[b*2 +: 2] : 2'b11;
            if (!is_rd && b < 4) model_write(a, b, wd[b*18 +: 18], be[b*2 +: 2]);
            @(negedge clk);
        end
        ld = 1'b0;
    endtask

    task automatic wr_then_rd(input logic [5:0] a, input logic [71:0] wd);
        align();
        for (int b = 0; b < 12; b++) begin
            if (b >= 7 && b <= 10) begin
                check_read_beat(a, b - 7);
                chk("R9 fresh data", rdata, m0[{a[5:2], 2'(a[1:0] + 2'(b - 7))}]);
            end else chk("R7 rvalid low", rvalid, 0);
            chk("R3 no perr", perr, 0);
            ld    = (b == 0) || (b == 4);
            rw    = (b == 4);
            addr  = a;
            wdata = (b < 4) ? wd[b*18 +: 18] : '0;
            wbe   = 2'b11;
            if (b < 4) model_write(a, b, wd[b*18 +: 18], 2'b11);
            @(negedge clk);
        end
        ld = 1'b0;
    endtask

    task automatic odd_strobe(input logic [5:0] a);
        align();
        @(negedge clk);
        chk("R2 odd beat", kphase, 1);
        for (int b = 0; b < 5; b++) begin
            chk("R8 odd perr", perr, (b == 2) ? 1 : 0);
            chk("R8 odd no data", rvalid, 0);
            ld = (b == 0); rw = 1'b0; addr = a; wdata = 18'h3FFFF; wbe = 2'b11;
            @(negedge clk);
        end
        ld = 1'b0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 3000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m0[i] = '0; m1[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rvalid", rvalid, 0);
        chk("R1 perr", perr, 0);
        chk("R1 rdata", rdata, 0);
        chk("R1 kphase", kphase, 0);
        // R2 alternation
        for (int i = 1; i < 5; i++) begin
            @(negedge clk);
            chk("R2 phase", kphase, i % 2);
        end
        // R1 array cleared
        burst(1'b1, 6'h00, '0, '0, -1, 1'b0);
        // R3 R6 plain write and read
        burst(1'b0, 6'h08, {18'h0DDDD, 18'h0CCCC, 18'h0BBBB, 18'h0AAAA}, 8'hFF, -1, 1'b0);
        burst(1'b1, 6'h08, '0, '0, -1, 1'b0);
        // R4 wrap from start 2, read back from 0 and 3
        burst(1'b0, 6'h12, {18'h14444, 18'h13333, 18'h12222, 18'h11111}, 8'hFF, -1, 1'b0);
        burst(1'b1, 6'h10, '0, '0, -1, 1'b0);
        burst(1'b1, 6'h13, '0, '0, -1, 1'b0);
        // R6 per-beat masks: 01, 10, 00, 11
        burst(1'b0, 6'h08, {18'h3F0F0, 18'h35555, 18'h2ABCD, 18'h01234}, 8'b11_00_10_01, -1, 1'b0);
        burst(1'b1, 6'h08, '0, '0, -1, 1'b0);
        // R9 read right behind write
        wr_then_rd(6'h1D, {18'h09999, 18'h08888, 18'h07777, 18'h06666});
        // R8 strobe during read burst (write to 0x20 ignored)
        burst(1'b1, 6'h08, '0, '0, 2, 1'b0);
        burst(1'b1, 6'h20, '0, '0, -1, 1'b0);
        // R8 strobe on odd beat inside a write burst
        burst(1'b0, 6'h2C, {18'h04444, 18'h03333, 18'h02222, 18'h01111}, 8'hFF, 1, 1'b0);
        burst(1'b1, 6'h2C, '0, '0, -1, 1'b0);
        burst(1'b1, 6'h20, '0, '0, -1, 1'b0);
        // R8 lone odd strobe, then verify nothing stored
        odd_strobe(6'h24);
        burst(1'b1, 6'h24, '0, '0, -1, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule